// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block takes a high-speed serial PHY from power-down to operation without software pacing. A one-cycle start pulse makes it clear the power switches, enable isolation and IDDQ, shut down and then reopen the analog blocks in a fixed order, and release the PLL and PHY resets. It waits a set number of microseconds between steps. One prescaler produces a microsecond tick from the clock, and one down-counter times every wait.

After the resets are released, the sequencer samples the PLL lock input once per microsecond. It gives up after a retry count taken from an input. If the first check runs out, it pulses the PLL reset low for one clock and runs the check once more. Pass or fail, it then moves the mode field to a hold value (non-driving-low) and returns to idle. It shows `done` on a lock or `fail` if the retry check also missed.

The states are, in order: S_IDLE → S_CLR_ON (start) → S_ISO → S_IDDQ → S_AFE_OFF → S_CORE → S_BG → S_LDO → S_OK → S_PLL → S_UNISO → S_UNIDDQ. Each of these moves on when its wait expires. The sequence continues S_UNIDDQ → S_REL → S_POLL1 (one clock each). From S_POLL1 the FSM goes to S_IDLE on a lock hit, or to S_PRST when the samples run out. S_PRST → S_POLL2 takes one clock. S_POLL2 → S_IDLE on a hit or when the samples run out.

Top module: `phy_pwrup_seq`

## Requirements
- R1: An asynchronous reset (rst_n low) puts the outputs in their reset state at once. `iso` and `iddq` are 1. Every power-down-bar, `core_rdy`, both switch outputs and both reset-bar outputs are 0. `busy`, `done` and `fail` are 0, `mode` is 0, and the FSM is idle.
- R2: A start pulse in idle acts in the same clock. `pwr_on_in`, `pll_rst_n`, `phy_rst_n`, `done` and `fail` go to 0 and `busy` goes to 1. 10 us later `pwr_ok_in` goes to 0 and `iso` to 1. 10 us after that `iddq` goes to 1.
- R3: 10 us after `iddq` rises, `bg_pd_n`, `pll_pd_n`, `ldo_pd_n` and `core_rdy` all go to 0 together, `mode` is loaded with MODE_PWRUP (5 in the bench), and this state holds for 160 us.
- R4: Next `core_rdy` goes to 1 for 50 us, then `bg_pd_n` goes to 1 for 200 us.
- R5: Next `pwr_on_in` and `ldo_pd_n` go to 1 in the same clock for 10 us, then `pwr_ok_in` goes to 1 for 10 us.
- R6: Next `pll_pd_n` goes to 1 for 10 us, `iso` goes to 0 for 10 us, and `iddq` goes to 0 for 1 us. Then `pll_rst_n` goes to 1, and `phy_rst_n` goes to 1 one clock later.
- R7: Lock checking begins when `phy_rst_n` rises. `pll_lock` is sampled only in the last clock of each microsecond, counted from the start of the check. The check ends on the first high sample. It gives up after `retry_limit` samples, and a limit of 0 counts as 1. A high level on `pll_lock` in any other clock has no effect.
- R8: When the first check runs out, `pll_rst_n` drops to 0 for exactly one clock, then returns to 1, and a second full check begins.
- R9: The clock after a hit or after the second check runs out, `busy` goes to 0 and `mode` becomes MODE_HOLD (2 in the bench). `done` goes to 1 on a hit, or `fail` goes to 1 if the second check ran out. All outputs hold until the next start.
- R10: A start pulse while `busy` is 1 has no effect on any output or on the timing of the sequence.
- R11: One microsecond is exactly CLKS_PER_US clocks, and each state lasts exactly its wait times CLKS_PER_US clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to start power-up |
| pll_lock | input | 1 | PLL lock indication from the PHY |
| retry_limit | input | RETRY_W | Number of lock samples per check (0 means 1) |
| iso | output | 1 | PHY isolation enable |
| iddq | output | 1 | PHY IDDQ (quiescent) enable |
| bg_pd_n | output | 1 | Bandgap power-down-bar |
| pll_pd_n | output | 1 | PLL power-down-bar |
| ldo_pd_n | output | 1 | LDO power-down-bar |
| core_rdy | output | 1 | Core-ready control |
| pwr_on_in | output | 1 | Power switch on request |
| pwr_ok_in | output | 1 | Power switch good indication |
| pll_rst_n | output | 1 | PLL reset-bar |
| phy_rst_n | output | 1 | PHY reset-bar |
| mode | output | MODE_W | PHY mode field |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence ended with PLL lock |
| fail | output | 1 | Last sequence ended without PLL lock |

## Verification
The bench builds the block with CLKS_PER_US = 3 and RETRY_W = 4. The full power-up then takes about 1,450 clocks, which leaves room for more than a dozen complete runs. A three-clock microsecond has distinct first, middle and last clocks. This lets the bench place a one-clock lock pulse exactly on a sample clock, or one clock before it, and so tell a correct sample point from an off-by-one. Retry limits of 0 to 5 make both checks short enough to cover a hit on the first sample, a hit on the last sample, a hit in the second check, and a full double failure.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR_ON,
        S_ISO,
        S_IDDQ,
        S_AFE_OFF,
        S_CORE,
        S_BG,
        S_LDO,
        S_OK,
        S_PLL,
        S_UNISO,
        S_UNIDDQ,
        S_REL,
        S_POLL1,
        S_PRST,
        S_POLL2
    } seq_state_t;

    localparam int unsigned WAIT_W = 8;

    // Dwell time in microseconds of each timed state.
    function automatic logic [WAIT_W-1:0] step_us(seq_state_t s);
        logic [WAIT_W-1:0] v;
        case (s)
            S_AFE_OFF: v = 8'd160;
            S_CORE:    v = 8'd50;
            S_BG:      v = 8'd200;
            S_UNIDDQ:  v = 8'd1;
            S_CLR_ON, S_ISO, S_IDDQ, S_LDO,
            S_OK, S_PLL, S_UNISO: v = 8'd10;
            default:   v = 8'd1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/usec_tick.sv
module usec_tick #(
    parameter int unsigned CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int unsigned PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;

    generate
        if (CLKS_PER_US <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_presc
            localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);
            logic [PW-1:0] presc;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    presc <= '0;
                else if (restart || presc == LAST)
                    presc <= '0;
                else
                    presc <= presc + 1'b1;
            end

            assign tick = (presc == LAST);
        end
    endgenerate
endmodule

// File: rtl/step_timer.sv
module step_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = tick && (cnt == W'(1));
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_pwrup_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 100,
    parameter int unsigned RETRY_W     = 8,
    parameter int unsigned MODE_W      = 3,
    parameter logic [MODE_W-1:0] MODE_PWRUP = MODE_W'(5),
    parameter logic [MODE_W-1:0] MODE_HOLD  = MODE_W'(2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               pll_lock,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               iso,
    output logic               iddq,
    output logic               bg_pd_n,
    output logic               pll_pd_n,
    output logic               ldo_pd_n,
    output logic               core_rdy,
    output logic               pwr_on_in,
    output logic               pwr_ok_in,
    output logic               pll_rst_n,
    output logic               phy_rst_n,
    output logic [MODE_W-1:0]  mode,
    output logic               busy,
    output logic               done,
    output logic               fail
);
    localparam int unsigned CNT_W = (RETRY_W > WAIT_W) ? RETRY_W : WAIT_W;

    seq_state_t state, nxt;
    logic       enter, tick, t_last, lock_hit, poll_out;
    logic [CNT_W-1:0] load_val, retry_eff;

    assign enter    = (nxt != state);
    assign lock_hit = tick && pll_lock;
    assign poll_out = t_last && !pll_lock;

    assign retry_eff = (retry_limit == '0) ? CNT_W'(1) : CNT_W'(retry_limit);
    assign load_val  = (nxt == S_POLL1 || nxt == S_POLL2) ? retry_eff
                                                          : CNT_W'(step_us(nxt));

    usec_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (enter),
        .tick    (tick)
    );

    step_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter),
        .load_val (load_val),
        .tick     (tick),
        .last     (t_last)
    );

    // Next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (start)  nxt = S_CLR_ON;
            S_CLR_ON:  if (t_last) nxt = S_ISO;
            S_ISO:     if (t_last) nxt = S_IDDQ;
            S_IDDQ:    if (t_last) nxt = S_AFE_OFF;
            S_AFE_OFF: if (t_last) nxt = S_CORE;
            S_CORE:    if (t_last) nxt = S_BG;
            S_BG:      if (t_last) nxt = S_LDO;
            S_LDO:     if (t_last) nxt = S_OK;
            S_OK:      if (t_last) nxt = S_PLL;
            S_PLL:     if (t_last) nxt = S_UNISO;
            S_UNISO:   if (t_last) nxt = S_UNIDDQ;
            S_UNIDDQ:  if (t_last) nxt = S_REL;
            S_REL:     nxt = S_POLL1;
            S_POLL1: begin
                if (lock_hit)      nxt = S_IDLE;
                else if (poll_out) nxt = S_PRST;
            end
            S_PRST:    nxt = S_POLL2;
            S_POLL2:   if (lock_hit || poll_out) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Registered outputs, updated on entry to each state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iso       <= 1'b1;
            iddq      <= 1'b1;
            bg_pd_n   <= 1'b0;
            pll_pd_n  <= 1'b0;
            ldo_pd_n  <= 1'b0;
            core_rdy  <= 1'b0;
            pwr_on_in <= 1'b0;
            pwr_ok_in <= 1'b0;
            pll_rst_n <= 1'b0;
            phy_rst_n <= 1'b0;
            mode      <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
        end else if (enter) begin
            unique case (nxt)
                S_CLR_ON: begin
                    pwr_on_in <= 1'b0;
                    pll_rst_n <= 1'b0;
                    phy_rst_n <= 1'b0;
                    busy      <= 1'b1;
                    done      <= 1'b0;
                    fail      <= 1'b0;
                end
                S_ISO: begin
                    pwr_ok_in <= 1'b0;
                    iso       <= 1'b1;
                end
                S_IDDQ:    iddq <= 1'b1;
                S_AFE_OFF: begin
                    bg_pd_n  <= 1'b0;
                    pll_pd_n <= 1'b0;
                    ldo_pd_n <= 1'b0;
                    core_rdy <= 1'b0;
                    mode     <= MODE_PWRUP;
                end
                S_CORE:    core_rdy <= 1'b1;
                S_BG:      bg_pd_n  <= 1'b1;
                S_LDO: begin
                    pwr_on_in <= 1'b1;
                    ldo_pd_n  <= 1'b1;
                end
                S_OK:      pwr_ok_in <= 1'b1;
                S_PLL:     pll_pd_n  <= 1'b1;
                S_UNISO:   iso       <= 1'b0;
                S_UNIDDQ:  iddq      <= 1'b0;
                S_REL:     pll_rst_n <= 1'b1;
                S_POLL1:   phy_rst_n <= 1'b1;
                S_PRST:    pll_rst_n <= 1'b0;
                S_POLL2:   pll_rst_n <= 1'b1;
                S_IDLE: begin
                    busy <= 1'b0;
                    mode <= MODE_HOLD;
                    done <= lock_hit;
                    fail <= !lock_hit;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk #(
    parameter int unsigned MODE_W = 3,
    parameter logic [MODE_W-1:0] MODE_HOLD = MODE_W'(2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iso,
    input logic              iddq,
    input logic              bg_pd_n,
    input logic              pll_pd_n,
    input logic              ldo_pd_n,
    input logic              core_rdy,
    input logic              pwr_on_in,
    input logic              pwr_ok_in,
    input logic              pll_rst_n,
    input logic              phy_rst_n,
    input logic [MODE_W-1:0] mode,
    input logic              busy,
    input logic              done,
    input logic              fail
);
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!done && !fail && !pwr_on_in && !phy_rst_n && !pll_rst_n));

    p_iddq_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iddq) |-> iso);

    p_bg_after_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bg_pd_n) |-> (core_rdy && !ldo_pd_n && !pll_pd_n));

    p_ok_after_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ok_in) |-> (pwr_on_in && ldo_pd_n));

    p_pll_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_rst_n) |-> (pll_pd_n && !iso && !iddq));

    p_phy_after_pll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_rst_n) |-> pll_rst_n);

    p_retry_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pll_rst_n) && phy_rst_n) |=> pll_rst_n);

    p_end_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ((done != fail) && mode == MODE_HOLD));
endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk #(
    .MODE_W    (MODE_W),
    .MODE_HOLD (MODE_HOLD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iso       (iso),
    .iddq      (iddq),
    .bg_pd_n   (bg_pd_n),
    .pll_pd_n  (pll_pd_n),
    .ldo_pd_n  (ldo_pd_n),
    .core_rdy  (core_rdy),
    .pwr_on_in (pwr_on_in),
    .pwr_ok_in (pwr_ok_in),
    .pll_rst_n (pll_rst_n),
    .phy_rst_n (phy_rst_n),
    .mode      (mode),
    .busy      (busy),
    .done      (done),
    .fail      (fail)
);

// File: tb/sim_phy_pwrup_seq.sv
module sim_phy_pwrup_seq;
    localparam int C  = 3;
    localparam int RW = 4;
    localparam int MW = 3;
    localparam logic [2:0] M_PWRUP = 3'd5;
    localparam logic [2:0] M_HOLD  = 3'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pll_lock = 1'b0;
    logic [RW-1:0] retry_limit = '0;
    logic iso, iddq, bg_pd_n, pll_pd_n, ldo_pd_n, core_rdy;
    logic pwr_on_in, pwr_ok_in, pll_rst_n, phy_rst_n, busy, done, fail;
    logic [MW-1:0] mode;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int la = 0, la_end = 0, lb = 0, lb_end = 0, ls = 0, ls_end = 0;
    logic [15:0] cur;

    phy_pwrup_seq #(
        .CLKS_PER_US (C),
        .RETRY_W     (RW),
        .MODE_W      (MW),
        .MODE_PWRUP  (M_PWRUP),
        .MODE_HOLD   (M_HOLD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .pll_lock(pll_lock),
        .retry_limit(retry_limit), .iso(iso), .iddq(iddq), .bg_pd_n(bg_pd_n),
        .pll_pd_n(pll_pd_n), .ldo_pd_n(ldo_pd_n), .core_rdy(core_rdy),
        .pwr_on_in(pwr_on_in), .pwr_ok_in(pwr_ok_in), .pll_rst_n(pll_rst_n),
        .phy_rst_n(phy_rst_n), .mode(mode), .busy(busy), .done(done), .fail(fail)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk)
        pll_lock <= (cyc >= la && cyc < la_end) || (cyc >= lb && cyc < lb_end) ||
                    (cyc >= ls && cyc < ls_end);

    // Vector: [15:13] mode, 12 iso, 11 iddq, 10 bg, 9 pll, 8 ldo, 7 core,
    // 6 on, 5 ok, 4 pll_rst_n, 3 phy_rst_n, 2 busy, 1 done, 0 fail
    function automatic logic [15:0] observed();
        return {mode, iso, iddq, bg_pd_n, pll_pd_n, ldo_pd_n, core_rdy,
                pwr_on_in, pwr_ok_in, pll_rst_n, phy_rst_n, busy, done, fail};
    endfunction

    function automatic logic [15:0] reset_vec();
        return {3'd0, 13'b1_1000_0000_0000};
    endfunction

    // Expected outputs after entering phase p, built from the requirements
    function automatic logic [15:0] apply(logic [15:0] v, int p);
        logic [15:0] r = v;
        case (p)
            0:  begin r[6] = 0; r[4] = 0; r[3] = 0; r[2] = 1; r[1] = 0; r[0] = 0; end
            1:  begin r[5] = 0; r[12] = 1; end
            2:  r[11] = 1;
            3:  begin r[10:7] = 4'b0000; r[15:13] = M_PWRUP; end
            4:  r[7] = 1;
            5:  r[10] = 1;
            6:  begin r[6] = 1; r[8] = 1; end
            7:  r[5] = 1;
            8:  r[9] = 1;
            9:  r[12] = 0;
            10: r[11] = 0;
            11: r[4] = 1;
            12: r[3] = 1;
            13: r[4] = 0;
            14: r[4] = 1;
            15: begin r[2] = 0; r[1] = 1; r[0] = 0; r[15:13] = M_HOLD; end
            default: begin r[2] = 0; r[1] = 0; r[0] = 1; r[15:13] = M_HOLD; end
        endcase
        return r;
    endfunction

    function automatic string tag(int p);
        case (p)
            0, 1, 2: return "R2";
            3:       return "R3";
            4, 5:    return "R4";
            6, 7:    return "R5";
            8, 9, 10, 11, 12: return "R6";
            13, 14:  return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(string req, logic [15:0] exp);
        checks++;
        if (observed() !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, observed(), exp, cyc);
        end
    endtask

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Previous vector must hold one clock before t (R11), new one at t
    task automatic step(int t, int p);
        wait_to(t - 1);
        chk({tag(p), "/R11 hold"}, cur);
        wait_to(t);
        cur = apply(cur, p);
        chk(tag(p), cur);
    endtask

    task automatic run_seq(int lim, int k1, int k2, bit spur, bit poke);
        int t0, e, e2, l;
        int tm[13];
        tm = '{0, 10*C, 20*C, 30*C, 190*C, 240*C, 440*C, 450*C, 460*C,
               470*C, 480*C, 481*C, 481*C + 1};
        l = (lim == 0) ? 1 : lim;
        retry_limit = RW'(lim);
        la = 0; la_end = 0; lb = 0; lb_end = 0; ls = 0; ls_end = 0;
        t0 = cyc + 1;
        start = 1'b1;
        e  = t0 + 481*C + 1;
        e2 = e + l*C + 1;
        if (k1 > 0) begin la = e + C*k1 - 1; la_end = la + 1; end
        if (spur) begin ls = e + C - 2; ls_end = ls + 1; end   // R7 off-sample pulse
        if (k1 == 0 && k2 > 0) begin lb = e2 + C*k2 - 1; lb_end = lb + 1; end
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < 13; p++) begin
            if (p == 0) begin
                wait_to(t0);
                cur = apply(cur, 0);
                chk("R2", cur);
            end else begin
                step(t0 + tm[p], p);
            end
            if (poke && p == 5) begin   // R10 start while busy
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        if (k1 > 0) begin
            step(e + C*k1, 15);                     // R7 hit in first check
        end else begin
            step(e + l*C, 13);                      // R7 limit reached
            step(e2, 14);
            if (k2 > 0) step(e2 + C*k2, 15);
            else        step(e2 + l*C, 16);
        end
        repeat (6) @(negedge clk);
        chk("R9 hold", cur);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        cur = reset_vec();
        chk("R1", cur);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", cur);

        run_seq(4, 1, 0, 1'b0, 1'b0);   // first sample hits
        run_seq(4, 4, 0, 1'b1, 1'b0);   // last sample hits, off-sample pulse ignored
        run_seq(3, 0, 2, 1'b1, 1'b1);   // retry path success, start poked while busy
        run_seq(2, 0, 0, 1'b0, 1'b0);   // double failure
        run_seq(0, 0, 0, 1'b0, 1'b0);   // limit 0 counts as one sample
        run_seq(0, 0, 1, 1'b0, 1'b0);

        for (int i = 0; i < 6; i++) begin
            int lim, k1, k2;
            bit sp;
            lim = 1 + int'($urandom % 5);
            k1  = int'($urandom % (lim + 1));
            k2  = int'($urandom % (lim + 1));
            sp  = (k1 != 1) && ($urandom % 2 == 1);
            run_seq(lim, k1, k2, sp, $urandom % 2 == 1);
        end

        // R1: asynchronous reset in mid-sequence
        retry_limit = RW'(2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        #1;
        cur = reset_vec();
        chk("R1 async", cur);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", cur);
        run_seq(2, 2, 0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule